// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by looking it up in a hashed page table held in memory. Each accepted request picks one of sixteen segment registers by its top four address bits. The block hashes that segment's virtual segment identifier with the page index to find a group of eight 64-bit table entries. It then reads those entries one at a time over a simple read port. If no entry in the first group matches, it searches a second group whose address is built from the bitwise complement of the hash. The result is either a physical address with the matching entry's attribute bits, or a page fault.

The segment registers live inside the block. Software writes one by presenting any address whose top nibble names the register, together with the new contents. The table origin and the hash mask are plain configuration inputs and must only change while the walker is idle. Requests and responses are valid/ready streams. A request is accepted only when the walker is idle. A response stays on the pins, unchanged, until the consumer raises ready. The memory read port carries one request at a time. The address holds until the memory accepts it, and the memory returns exactly one 64-bit beat per accepted read, in any later cycle.

Top module: `hpt_walker`

## Requirements
- R1: A segment write stores the data into the register named by bits 31:28 of the write address; a translation uses the register named by bits 31:28 of the request address.
- R2: A segment register whose bit 31 is set makes the request fault with no memory read.
- R3: A segment register with bit 28 set makes an instruction-fetch request (req_ifetch=1) fault with no memory read; a data request through the same segment translates normally.
- R4: The first group address is {org[15:9], (hash[18:10] & mask) | org[8:0], hash[9:0], 6'b0}, where hash = segment[18:0] XOR {3'b0, ea[27:12]}. Slot s of a group is read at the group address + 8*s.
- R5: An entry (upper word in data bits 63:32) matches only if bit 63 (valid) is 1, bits 62:39 equal segment bits 23:0, bit 38 (H) equals the current pass (0 first, 1 second), and bits 37:32 equal ea[27:22].
- R6: Slots are read in ascending order; the first match ends the walk, and no further reads are issued.
- R7: When no slot of the first group matches, the eight slots of the second group are read, using the bitwise complement of the 19-bit hash; a hit there raises rsp_secondary.
- R8: On a hit, rsp_pa = {data[31:12], ea[11:0]}, rsp_wimg = data[6:3], rsp_pp = data[1:0], rsp_ref = data[8], rsp_chg = data[7].
- R9: After sixteen reads without a match the walker returns a fault, with rsp_pa and all attribute outputs zero.
- R10: busy rises in the cycle after a request is accepted and falls in the cycle after the response handshake; req_ready is low while busy.
- R11: While rsp_valid is high and rsp_ready is low, the response stays valid and all its fields are unchanged.
- R12: While mem_req_valid is high and mem_req_ready is low, the read request and its address hold; no new read is issued before the previous beat has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_ea | input | 32 | Address whose bits 31:28 select the register to write |
| seg_wr_data | input | 32 | New segment register contents |
| cfg_org | input | 16 | Table origin, upper 16 physical address bits |
| cfg_mask | input | 9 | Hash mask for the maskable origin bits |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_ea | input | 32 | Effective address to translate |
| req_ifetch | input | 1 | Request is an instruction fetch |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Entry, upper word in bits 63:32 |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Page fault |
| rsp_pa | output | 32 | Physical address |
| rsp_wimg | output | 4 | Storage attribute bits of the entry |
| rsp_pp | output | 2 | Protection bits of the entry |
| rsp_ref | output | 1 | Referenced bit of the entry |
| rsp_chg | output | 1 | Changed bit of the entry |
| rsp_secondary | output | 1 | Hit came from the second group |
| busy | output | 1 | Walk in progress |

## Verification
The hardest situation to reach from the ports is a hit in the second group that sits behind decoys. The first group must be full of entries that almost match: invalid entries, a foreign segment ID, a wrong page tag, or H set. The second group must also hold an H=0 entry ahead of the real one. The bench writes such tables into its sparse memory model. Some are placed by hand; others come from random scenarios that put the true entry in either group at a random slot and scatter near-miss entries around it. All of this runs under random memory stalls, random read latency and response back-pressure.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int EA_W   = 32;
  localparam int VSID_W = 24;
  localparam int HASH_W = 19;
  localparam int PIDX_W = 16;
  localparam int API_W  = 6;
  localparam int RPN_W  = 20;
  localparam int OFS_W  = 12;
  localparam int PTE_W  = 64;

  // Entry layout, most significant field first.
  typedef struct packed {
    logic              valid;
    logic [VSID_W-1:0] vsid;
    logic              hsel;
    logic [API_W-1:0]  api;
    logic [RPN_W-1:0]  rpn;
    logic [2:0]        rsv_a;
    logic              refd;
    logic              chg;
    logic [3:0]        wimg;
    logic              rsv_b;
    logic [1:0]        pp;
  } pte_t;

  typedef struct packed {
    logic              direct;
    logic              kprot_s;
    logic              kprot_u;
    logic              noexec;
    logic [3:0]        rsv;
    logic [VSID_W-1:0] vsid;
  } seg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } walk_st_e;

endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile #(
  parameter int NUM_SEG = 16,
  parameter int SEG_W   = 32,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);

  logic [SEG_W-1:0] regs [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        regs[i] <= wr_data;
    end
  end

  assign rd_data = regs[rd_idx];

endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int ORG_W  = 16,
  parameter int MASK_W = 9
) (
  input  logic [hpt_pkg::VSID_W-1:0] vsid,
  input  logic [hpt_pkg::PIDX_W-1:0] page_idx,
  input  logic                       secondary,
  input  logic [ORG_W-1:0]           org,
  input  logic [MASK_W-1:0]          mask,
  output logic [hpt_pkg::EA_W-1:0]   group_addr
);
  import hpt_pkg::*;

  localparam int FIX_W = ORG_W - MASK_W;
  localparam int LOW_W = HASH_W - MASK_W;
  localparam int GRP_W = EA_W - ORG_W - LOW_W;

  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;
  logic [MASK_W-1:0] h_mid;

  always_comb begin
    h_pri = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, page_idx};
    h_sel = secondary ? ~h_pri : h_pri;
    h_mid = (h_sel[HASH_W-1 -: MASK_W] & mask) | org[MASK_W-1:0];
    group_addr = {org[ORG_W-1 -: FIX_W], h_mid, h_sel[LOW_W-1:0], {GRP_W{1'b0}}};
  end

endmodule

// File: rtl/hpt_match.sv
module hpt_match (
  input  hpt_pkg::pte_t                  entry,
  input  logic [hpt_pkg::VSID_W-1:0]     vsid,
  input  logic [hpt_pkg::API_W-1:0]      api,
  input  logic                           pass,
  output logic                           hit
);

  always_comb begin
    hit = entry.valid && (entry.vsid == vsid) &&
          (entry.hsel == pass) && (entry.api == api);
  end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int NUM_SEG     = 16,
  parameter int GROUP_SLOTS = 8,
  parameter int ORG_W       = 16,
  parameter int MASK_W      = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seg_wr_en,
  input  logic [31:0] seg_wr_ea,
  input  logic [31:0] seg_wr_data,
  input  logic [15:0] cfg_org,
  input  logic [8:0]  cfg_mask,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_ea,
  input  logic        req_ifetch,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_fault,
  output logic [31:0] rsp_pa,
  output logic [3:0]  rsp_wimg,
  output logic [1:0]  rsp_pp,
  output logic        rsp_ref,
  output logic        rsp_chg,
  output logic        rsp_secondary,
  output logic        busy
);
  import hpt_pkg::*;

  localparam int IDX_W   = $clog2(NUM_SEG);
  localparam int SLOT_W  = $clog2(GROUP_SLOTS);
  localparam int ENT_B   = $clog2(PTE_W / 8);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

  walk_st_e          state_q;
  logic [EA_W-1:0]   ea_q;
  logic [VSID_W-1:0] vsid_q;
  logic              pass_q;
  logic [SLOT_W-1:0] slot_q;

  logic              res_fault_q;
  logic [EA_W-1:0]   res_pa_q;
  logic [3:0]        res_wimg_q;
  logic [1:0]        res_pp_q;
  logic              res_ref_q;
  logic              res_chg_q;
  logic              res_sec_q;

  // Segment register file, indexed by the top address nibble.
  logic [31:0] seg_raw;
  seg_t        seg_rd;

  hpt_segfile #(.NUM_SEG(NUM_SEG), .SEG_W(32)) u_segs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_idx  (seg_wr_ea[EA_W-1 -: IDX_W]),
    .wr_data (seg_wr_data),
    .rd_idx  (req_ea[EA_W-1 -: IDX_W]),
    .rd_data (seg_raw)
  );
  assign seg_rd = seg_t'(seg_raw);

  // Group address for the current pass.
  logic [EA_W-1:0] group_addr;

  hpt_hash #(.ORG_W(ORG_W), .MASK_W(MASK_W)) u_hash (
    .vsid       (vsid_q),
    .page_idx   (ea_q[EA_W-IDX_W-1 -: PIDX_W]),
    .secondary  (pass_q),
    .org        (cfg_org),
    .mask       (cfg_mask),
    .group_addr (group_addr)
  );

  // Compare of the returned entry.
  pte_t beat;
  logic beat_hit;
  assign beat = pte_t'(mem_rsp_data);

  hpt_match u_match (
    .entry (beat),
    .vsid  (vsid_q),
    .api   (ea_q[EA_W-IDX_W-1 -: API_W]),
    .pass  (pass_q),
    .hit   (beat_hit)
  );

  logic seg_fault;
  assign seg_fault = seg_rd.direct || (seg_rd.noexec && req_ifetch);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ea_q        <= '0;
      vsid_q      <= '0;
      pass_q      <= 1'b0;
      slot_q      <= '0;
      res_fault_q <= 1'b0;
      res_pa_q    <= '0;
      res_wimg_q  <= '0;
      res_pp_q    <= '0;
      res_ref_q   <= 1'b0;
      res_chg_q   <= 1'b0;
      res_sec_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            ea_q   <= req_ea;
            vsid_q <= seg_rd.vsid;
            pass_q <= 1'b0;
            slot_q <= '0;
            if (seg_fault) begin
              res_fault_q <= 1'b1;
              res_pa_q    <= '0;
              res_wimg_q  <= '0;
              res_pp_q    <= '0;
              res_ref_q   <= 1'b0;
              res_chg_q   <= 1'b0;
              res_sec_q   <= 1'b0;
              state_q     <= ST_RESP;
            end else begin
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            if (beat_hit) begin
              res_fault_q <= 1'b0;
              res_pa_q    <= {beat.rpn, ea_q[OFS_W-1:0]};
              res_wimg_q  <= beat.wimg;
              res_pp_q    <= beat.pp;
              res_ref_q   <= beat.refd;
              res_chg_q   <= beat.chg;
              res_sec_q   <= pass_q;
              state_q     <= ST_RESP;
            end else if (slot_q == LAST_SLOT) begin
              if (!pass_q) begin
                pass_q  <= 1'b1;
                slot_q  <= '0;
                state_q <= ST_ISSUE;
              end else begin
                res_fault_q <= 1'b1;
                res_pa_q    <= '0;
                res_wimg_q  <= '0;
                res_pp_q    <= '0;
                res_ref_q   <= 1'b0;
                res_chg_q   <= 1'b0;
                res_sec_q   <= 1'b0;
                state_q     <= ST_RESP;
              end
            end else begin
              slot_q  <= slot_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = group_addr | (EA_W'(slot_q) << ENT_B);
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_fault     = res_fault_q;
  assign rsp_pa        = res_pa_q;
  assign rsp_wimg      = res_wimg_q;
  assign rsp_pp        = res_pp_q;
  assign rsp_ref       = res_ref_q;
  assign rsp_chg       = res_chg_q;
  assign rsp_secondary = res_sec_q;

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int GROUP_SLOTS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_fault,
  input logic [31:0] rsp_pa,
  input logic        rsp_secondary
);

  localparam int CNT_W = $clog2(2 * GROUP_SLOTS + 1) + 1;
  localparam logic [CNT_W-1:0] ALL_READS = CNT_W'(2 * GROUP_SLOTS);
  localparam logic [CNT_W-1:0] ONE_GROUP = CNT_W'(GROUP_SLOTS);

  logic [CNT_W-1:0] rd_cnt;
  logic             outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      outst  <= 1'b0;
    end else begin
      if (req_valid && req_ready)
        rd_cnt <= '0;
      else if (mem_req_valid && mem_req_ready)
        rd_cnt <= rd_cnt + 1'b1;
      if (mem_req_valid && mem_req_ready)
        outst <= 1'b1;
      else if (mem_rsp_valid)
        outst <= 1'b0;
    end
  end

  p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_busy_noready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) &&
                                   $stable(rsp_fault) && $stable(rsp_secondary)));
  p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  p_one_outst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst);
  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  p_read_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= ALL_READS);
  p_fault_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rd_cnt == '0 || rd_cnt == ALL_READS));
  p_sec_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && rsp_secondary) |-> (rd_cnt > ONE_GROUP));
  p_pri_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && !rsp_secondary) |-> (rd_cnt >= 1 && rd_cnt <= ONE_GROUP));

endmodule

bind hpt_walker hpt_walker_chk #(.GROUP_SLOTS(GROUP_SLOTS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_pa        (rsp_pa),
  .rsp_secondary (rsp_secondary)
);

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [31:0] seg_wr_ea = '0;
  logic [31:0] seg_wr_data = '0;
  logic [15:0] cfg_org = 16'h1200;
  logic [8:0]  cfg_mask = 9'h00F;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic        req_ifetch = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [31:0] rsp_pa;
  logic [3:0]  rsp_wimg;
  logic [1:0]  rsp_pp;
  logic        rsp_ref;
  logic        rsp_chg;
  logic        rsp_secondary;
  logic        busy;

  always #5 clk = ~clk;

  hpt_walker dut_i (.*);

  int n_total = 0;
  int n_fail  = 0;

  logic [63:0] memory [logic [31:0]];
  logic [31:0] seg_m [16];
  int          nreads;
  logic [31:0] addr_log [16];

  // Observed response
  logic        o_fault, o_ref, o_chg, o_sec;
  logic [31:0] o_pa;
  logic [3:0]  o_wimg;
  logic [1:0]  o_pp;

  // Reference response
  logic        e_fault, e_ref, e_chg, e_sec;
  logic [31:0] e_pa;
  logic [3:0]  e_wimg;
  logic [1:0]  e_pp;
  int          e_reads;

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic v, input logic [23:0] vsid, input logic h,
      input logic [5:0] api, input logic [19:0] rpn, input logic r, input logic c,
      input logic [3:0] wimg, input logic [1:0] pp);
    return {v, vsid, h, api, rpn, 3'b000, r, c, wimg, 1'b0, pp};
  endfunction

  function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [31:0] ea, input logic sec);
    logic [18:0] h;
    h = vsid[18:0] ^ {3'b000, ea[27:12]};
    if (sec) h = ~h;
    return {cfg_org[15:9], (h[18:10] & cfg_mask) | cfg_org[8:0], h[9:0], 6'b0};
  endfunction

  function automatic logic [63:0] rd_mem(input logic [31:0] a);
    return memory.exists(a) ? memory[a] : 64'd0;
  endfunction

  task automatic put(input logic [31:0] ea, input logic sec, input int slot, input logic [63:0] e);
    memory[grp(seg_m[ea[31:28]][23:0], ea, sec) + 32'(slot * 8)] = e;
  endtask

  task automatic ref_walk(input logic [31:0] ea, input logic ifetch);
    logic [31:0] sr;
    logic [63:0] e;
    sr = seg_m[ea[31:28]];
    e_fault = 1'b1; e_pa = '0; e_wimg = '0; e_pp = '0; e_ref = 0; e_chg = 0; e_sec = 0; e_reads = 0;
    if (sr[31] || (sr[28] && ifetch)) return;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        e_reads++;
        e = rd_mem(grp(sr[23:0], ea, p[0]) + 32'(s * 8));
        if (e[63] && e[62:39] == sr[23:0] && e[38] == p[0] && e[37:32] == ea[27:22]) begin
          e_fault = 0; e_pa = {e[31:12], ea[11:0]}; e_wimg = e[6:3]; e_pp = e[1:0];
          e_ref = e[8]; e_chg = e[7]; e_sec = p[0];
          return;
        end
      end
    end
  endtask

  task automatic wr_seg(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    seg_wr_en = 1'b1;
    seg_wr_ea = {idx, 28'($urandom)};
    seg_wr_data = d;
    seg_m[idx] = d;
    @(negedge clk);
    seg_wr_en = 1'b0;
  endtask

  // Memory model: random stalls, random latency, one read outstanding.
  initial begin
    logic        pend = 0;
    int          cnt = 0;
    logic [31:0] paddr = '0;
    logic        prev_stall = 0;
    logic [31:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = rd_mem(paddr);
          pend = 0;
        end else cnt--;
      end
      if (prev_stall)
        check(mem_req_valid && mem_req_addr == prev_addr, "R12 held read",
              {31'd0, mem_req_valid, mem_req_addr}, {32'd1, prev_addr});
      mem_req_ready = ($urandom % 4) != 0;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        if (nreads < 16) addr_log[nreads] = mem_req_addr;
        nreads++;
        pend = 1;
        cnt = $urandom % 3;
        paddr = mem_req_addr;
      end
    end
  end

  task automatic xact(input logic [31:0] ea, input logic ifetch, input int hold);
    int waited;
    logic got;
    logic [31:0] s_pa;
    logic s_fault;
    nreads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_ifetch = ifetch;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R10 busy after accept", {62'd0, busy, req_ready}, 64'h2);
    waited = 0; got = 0; s_pa = '0; s_fault = 0;
    while (!got) begin
      if (rsp_valid) begin
        if (waited == 0) begin
          s_pa = rsp_pa; s_fault = rsp_fault;
        end else
          check(rsp_pa == s_pa && rsp_fault == s_fault, "R11 held response",
                {31'd0, rsp_fault, rsp_pa}, {31'd0, s_fault, s_pa});
        if (waited >= hold) begin
          rsp_ready = 1'b1; got = 1;
          o_fault = rsp_fault; o_pa = rsp_pa; o_wimg = rsp_wimg; o_pp = rsp_pp;
          o_ref = rsp_ref; o_chg = rsp_chg; o_sec = rsp_secondary;
        end
        waited++;
      end
      if (!got) @(negedge clk);
    end
    @(negedge clk);
    rsp_ready = 1'b0;
    check(!busy && req_ready, "R10 idle after response", {62'd0, busy, req_ready}, 64'h1);
  endtask

  task automatic run_cmp(input logic [31:0] ea, input logic ifetch, input int hold, input string tag);
    ref_walk(ea, ifetch);
    xact(ea, ifetch, hold);
    check({o_fault, o_pa, o_wimg, o_pp, o_ref, o_chg, o_sec} ==
          {e_fault, e_pa, e_wimg, e_pp, e_ref, e_chg, e_sec} && nreads == e_reads, tag,
          {o_fault, o_pa, o_wimg, o_pp, o_ref, o_chg, o_sec, 8'(nreads)},
          {e_fault, e_pa, e_wimg, e_pp, e_ref, e_chg, e_sec, 8'(e_reads)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [31:0] ea;
    logic [23:0] va;
    for (int i = 0; i < 16; i++) seg_m[i] = '0;
    repeat (3) @(negedge clk);
    check(!busy && req_ready && !mem_req_valid && !rsp_valid, "R10 reset state",
          {60'd0, busy, req_ready, mem_req_valid, rsp_valid}, 64'h4);
    rst_n = 1'b1;

    // R4 / R8: hit in slot 0 of the first group
    wr_seg(4'h1, 32'h000A_BCDE);
    ea = 32'h1234_5678;
    put(ea, 0, 0, mk_pte(1, 24'h0ABCDE, 0, ea[27:22], 20'hC0FFE, 1, 0, 4'b1010, 2'b10));
    run_cmp(ea, 0, 0, "R8 first-group hit");
    check(addr_log[0] == grp(24'h0ABCDE, ea, 0), "R4 group address", {32'd0, addr_log[0]},
          {32'd0, grp(24'h0ABCDE, ea, 0)});
    check(o_pa == 32'hC0FF_E678 && o_wimg == 4'b1010 && o_pp == 2'b10 && o_ref && !o_chg,
          "R8 fields", {o_pa, o_wimg, o_pp, o_ref, o_chg}, {32'hC0FFE678, 4'b1010, 2'b10, 2'b10});

    // R6: first of two matches wins, walk stops
    memory.delete();
    put(ea, 0, 2, mk_pte(1, 24'h0ABCDE, 0, ea[27:22], 20'h00002, 0, 1, 4'h0, 2'b01));
    put(ea, 0, 5, mk_pte(1, 24'h0ABCDE, 0, ea[27:22], 20'h00005, 0, 1, 4'h0, 2'b01));
    xact(ea, 0, 0);
    check(o_pa[31:12] == 20'h00002 && nreads == 3, "R6 first slot wins",
          {o_pa, 32'(nreads)}, {32'h0000_2678, 32'd3});

    // R5: near-miss entries are skipped
    memory.delete();
    put(ea, 0, 0, mk_pte(0, 24'h0ABCDE, 0, ea[27:22], 20'h11111, 0, 0, 0, 0));
    put(ea, 0, 1, mk_pte(1, 24'h0ABCDF, 0, ea[27:22], 20'h22222, 0, 0, 0, 0));
    put(ea, 0, 2, mk_pte(1, 24'h0ABCDE, 0, ~ea[27:22], 20'h33333, 0, 0, 0, 0));
    put(ea, 0, 3, mk_pte(1, 24'h0ABCDE, 1, ea[27:22], 20'h44444, 0, 0, 0, 0));
    put(ea, 0, 4, mk_pte(1, 24'h0ABCDE, 0, ea[27:22], 20'h55555, 0, 0, 0, 0));
    xact(ea, 0, 1);
    check(!o_fault && o_pa[31:12] == 20'h55555 && nreads == 5, "R5 match rules",
          {o_pa, 32'(nreads)}, {32'h5555_5678, 32'd5});

    // R7: second group, H must be 1
    memory.delete();
    put(ea, 1, 0, mk_pte(1, 24'h0ABCDE, 0, ea[27:22], 20'h66666, 0, 0, 0, 0));
    put(ea, 1, 1, mk_pte(1, 24'h0ABCDE, 1, ea[27:22], 20'h77777, 1, 1, 4'h5, 2'b11));
    xact(ea, 0, 0);
    check(!o_fault && o_sec && o_pa[31:12] == 20'h77777 && nreads == 10, "R7 second group hit",
          {o_sec, o_pa, 31'(nreads)}, {1'b1, 32'h7777_7678, 31'd10});
    check(addr_log[8] == grp(24'h0ABCDE, ea, 1), "R7 complemented hash address",
          {32'd0, addr_log[8]}, {32'd0, grp(24'h0ABCDE, ea, 1)});

    // R9: exhaustion fault with held response (R11)
    memory.delete();
    xact(ea, 0, 4);
    check(o_fault && o_pa == 0 && o_wimg == 0 && o_pp == 0 && nreads == 16, "R9 exhausted fault",
          {o_fault, o_pa, 31'(nreads)}, {1'b1, 32'd0, 31'd16});

    // R2: direct segment faults with no reads
    wr_seg(4'h2, 32'h8000_0123);
    xact(32'h2000_1000, 0, 0);
    check(o_fault && nreads == 0, "R2 segment fault", {o_fault, 63'(nreads)}, {1'b1, 63'd0});

    // R3: no-execute segment
    wr_seg(4'h3, 32'h1000_0111);
    ea = 32'h3ABC_D123;
    put(ea, 0, 0, mk_pte(1, 24'h000111, 0, ea[27:22], 20'hABCDE, 0, 0, 0, 0));
    xact(ea, 1, 0);
    check(o_fault && nreads == 0, "R3 fetch faults", {o_fault, 63'(nreads)}, {1'b1, 63'd0});
    xact(ea, 0, 0);
    check(!o_fault && o_pa == 32'hABCD_E123, "R3 data translates", {o_fault, o_pa}, {1'b0, 32'hABCDE123});

    // R1: segment selection by top nibble
    wr_seg(4'h4, 32'h0012_3456);
    wr_seg(4'h5, 32'h0065_4321);
    ea = 32'h4000_5ABC;
    put(ea, 0, 3, mk_pte(1, 24'h123456, 0, ea[27:22], 20'h0F00F, 0, 0, 0, 0));
    xact(ea, 0, 0);
    check(!o_fault && o_pa == 32'h0F00_FABC, "R1 segment 4 used", {o_fault, o_pa}, {1'b0, 32'h0F00FABC});
    xact(32'h5000_5ABC, 0, 0);
    check(o_fault, "R1 segment 5 differs", {63'd0, o_fault}, 64'd1);
    wr_seg(4'h4, 32'h0065_4321);
    xact(ea, 0, 0);
    check(o_fault, "R1 rewrite of segment 4", {63'd0, o_fault}, 64'd1);

    // Random scenarios
    for (int it = 0; it < 150; it++) begin
      logic [3:0] sidx;
      int scen, slot;
      memory.delete();
      cfg_mask = 9'((1 << ($urandom % 10)) - 1);
      cfg_org = 16'($urandom) & ~{7'd0, cfg_mask};
      ea = $urandom;
      sidx = ea[31:28];
      va = 24'($urandom);
      wr_seg(sidx, {($urandom % 16) == 0, 2'b00, ($urandom % 4) == 0, 4'h0, va});
      scen = $urandom % 3;
      slot = $urandom % 8;
      for (int d = 0; d < 6; d++)
        put(ea, 1'($urandom), $urandom % 8,
            mk_pte(1'($urandom), va ^ 24'($urandom % 2), 1'($urandom), ea[27:22] ^ 6'($urandom % 2),
                   20'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom)));
      if (scen != 0)
        put(ea, scen == 2, slot, mk_pte(1, va, scen == 2, ea[27:22], 20'($urandom),
                                        1'($urandom), 1'($urandom), 4'($urandom), 2'($urandom)));
      run_cmp(ea, 1'($urandom), $urandom % 3, "R8 random walk");
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule